// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block produces the serial clock for an I2C controller acting as bus master. A full SCL period lasts 16 + 2·R·4^P system clock cycles, where R is an 8-bit bit-rate value and P is a 2-bit prescaler select that scales R by 1, 4, 16 or 64. The period splits into a low half and a high half, each of 8 + R·4^P cycles. The block drives SCL in open-drain style: it can only pull the line low or let it go.

The generator watches the real line level through a two-flop synchronizer. A slave that holds SCL low after the release makes the period longer, because high-phase timing starts only once the line is sensed high. The high count is shortened by the three cycles of synchronizer and detection delay. On an undisturbed line the period is therefore exact. The controller can also raise a hold request at the end of a low half. This keeps SCL low for as long as it needs, for example while its event flag waits for service. Two single-cycle strobes mark the start of each low half and of each timed high half for the bit engine.

The settings are sampled at the start of every period. Dropping the enable releases the line and parks the generator.

Top module: `scl_rate_gen`

## Requirements
- R1: During reset and afterwards with enable low, `scl_pull_low`, `low_start` and `high_start` are all 0.
- R2: On a line that follows the drive with no stretching, one SCL period (cycles with `scl_pull_low`=1 plus the cycles with it 0 that follow) is 16 + 2·R·4^P clocks. `rate` is R, and `prescale` values 0,1,2,3 multiply R by 1,4,16,64.
- R3: Each low half, with no hold request, keeps `scl_pull_low` at 1 for exactly 8 + R·4^P clocks.
- R4: If the line is kept low by another device for S clocks after the release, the released interval grows to 8 + R·4^P + S clocks.
- R5: If `hold_low` is 1 at the end of a low half, `scl_pull_low` stays 1 while it remains 1. It goes to 0 at the first clock edge that samples `hold_low`=0.
- R6: Taking `enable` low releases the line (`scl_pull_low`=0) from the next clock edge on, with no strobes, whatever `hold_low` does. Raising `enable` starts a low half at the next clock edge.
- R7: `low_start` is 1 for one clock, in the first cycle of each low half. `high_start` is 1 for exactly one clock per period, in the first cycle of timed high, while the line is released.
- R8: `rate` and `prescale` are sampled when a low half starts. A change during a period does not alter that period's low or high length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Master-mode run enable |
| rate | input | 8 | Bit-rate value R |
| prescale | input | 2 | Prescaler select P (×1, ×4, ×16, ×64) |
| scl_sense | input | 1 | Observed SCL line level (asynchronous) |
| hold_low | input | 1 | Controller request to keep SCL low |
| scl_pull_low | output | 1 | 1 = pull SCL low, 0 = release |
| low_start | output | 1 | Pulse in first cycle of a low half |
| high_start | output | 1 | Pulse in first cycle of timed high |

## Verification
Directed settings cover the smallest half (R=0), the largest bit-rate at ×1, and every prescaler step including ×64. A batch of random R/P pairs shows that the period formula holds beyond hand-picked points. Runs with different line-stretch lengths show that the released interval grows by exactly the stretch, which separates real level sensing from free-running timing. A long hold request, a settings change in the middle of a period, and an enable drop show that holding, per-period sampling and release each act in the right cycle.

// File: rtl/scl_gen_pkg.sv
// Package: shared types and constants of the SCL rate generator.
// Assumes: nothing beyond IEEE 1800-2017.
package scl_gen_pkg;
    // phase of the generated clock
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_LOW     = 2'd1,
        PH_WAIT_HI = 2'd2,
        PH_HIGH    = 2'd3
    } phase_e;

    // fixed part of one half period, in system clocks
    localparam int unsigned HALF_BASE = 8;
endpackage

// File: rtl/scl_line_sync.sv
// Module: scl_line_sync
// Brings the asynchronous SCL line level into the clock domain through a
// chain of STAGES flops. Assumes an idle bus is pulled high, so every
// stage resets to 1.
module scl_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_q
);
    logic [STAGES-1:0] chain;

    // shift the line level through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], line_in};
    end

    assign line_q = chain[STAGES-1];
endmodule

// File: rtl/scl_half_calc.sv
// Module: scl_half_calc
// Computes the half-period length HALF_BASE + R * 4^P. The scaled terms
// for every prescaler step are built in a generate loop and one is picked
// by the select. Assumes HALF_W is wide enough for the largest result.
module scl_half_calc
    import scl_gen_pkg::*;
#(
    parameter int unsigned RATE_W = 8,
    parameter int unsigned PS_W   = 2,
    parameter int unsigned HALF_W = RATE_W + 2 * ((1 << PS_W) - 1) + 1
) (
    input  logic [RATE_W-1:0] rate,
    input  logic [PS_W-1:0]   prescale,
    output logic [HALF_W-1:0] half_len
);
    localparam int unsigned NSTEP = 1 << PS_W;

    logic [HALF_W-1:0] scaled [NSTEP];

    for (genvar g = 0; g < NSTEP; g++) begin : g_step
        // rate multiplied by 4^g
        assign scaled[g] = HALF_W'(rate) << (2 * g);
    end

    // pick the scaled term for the selected step and add the fixed part
    always_comb begin
        half_len = HALF_W'(HALF_BASE) + scaled[prescale];
    end
endmodule

// File: rtl/scl_phase_fsm.sv
// Module: scl_phase_fsm
// Sequences low, wait-for-line-high and timed-high phases. The half length
// is latched when a low half starts, so one period always uses one value.
// The high count is cut by SYNC_LAT to cover the synchronizer and the
// detection cycle. Assumes half_now >= SYNC_LAT + 2.
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int unsigned HALF_W   = 15,
    parameter int unsigned SYNC_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              hold_low,
    input  logic              line_high,
    input  logic [HALF_W-1:0] half_now,
    output logic              pull_low,
    output logic              low_start,
    output logic              high_start
);
    phase_e            state, state_n;
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] half_q;
    logic              low_done, high_done;

    assign low_done  = (cnt == half_q - HALF_W'(1));
    assign high_done = (cnt == half_q - HALF_W'(SYNC_LAT + 1));

    // choose the next phase
    always_comb begin
        state_n = state;
        unique case (state)
            PH_IDLE:    state_n = PH_LOW;
            PH_LOW:     if (low_done && !hold_low) state_n = PH_WAIT_HI;
            PH_WAIT_HI: if (line_high) state_n = PH_HIGH;
            PH_HIGH:    if (high_done) state_n = PH_LOW;
            default:    state_n = PH_IDLE;
        endcase
        if (!enable) state_n = PH_IDLE;
    end

    // phase register, half-length latch and strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= PH_IDLE;
            half_q     <= '0;
            low_start  <= 1'b0;
            high_start <= 1'b0;
        end else begin
            state      <= state_n;
            low_start  <= (state_n == PH_LOW) && (state != PH_LOW);
            high_start <= (state_n == PH_HIGH) && (state != PH_HIGH);
            if ((state_n == PH_LOW) && (state != PH_LOW)) half_q <= half_now;
        end
    end

    // phase counter: cleared on a phase change, saturates at the low-half end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state_n != state) begin
            cnt <= '0;
        end else if ((state == PH_LOW && !low_done) || state == PH_HIGH) begin
            cnt <= cnt + HALF_W'(1);
        end
    end

    assign pull_low = (state == PH_LOW);

    // disabling releases the line and silences strobes (R6)
    assert_release_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pull_low && !low_start && !high_start));

    // a pending hold keeps the line low (R5)
    assert_hold_keeps_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_low && hold_low && enable) |=> pull_low);

    // no timed high and no new low before the line is seen high (R4)
    assert_wait_for_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_WAIT_HI && !line_high && enable) |=> (!pull_low && !high_start));

    // low counter never passes the latched half (R3)
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_LOW) |-> (cnt < half_q));

    // latched half never below the fixed part while running (R2)
    assert_half_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_IDLE) |-> (half_q >= HALF_W'(HALF_BASE)));

    // strobes never coincide, and each new low drive carries its strobe (R7)
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(low_start && high_start));
    assert_low_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_low) |-> low_start);

    // latched settings stay fixed within a period (R8)
    assert_half_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_IDLE && !low_start) |-> $stable(half_q));
endmodule

// File: rtl/scl_rate_gen.sv
// Module: scl_rate_gen (top)
// Master-mode SCL generator: period 16 + 2*R*4^P system clocks, open-drain
// drive, slave stretching honoured through the sensed line, local hold.
// Assumes scl_sense reflects the wired line including this block's drive.
module scl_rate_gen #(
    parameter int unsigned RATE_W      = 8,
    parameter int unsigned PS_W        = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [RATE_W-1:0] rate,
    input  logic [PS_W-1:0]   prescale,
    input  logic              scl_sense,
    input  logic              hold_low,
    output logic              scl_pull_low,
    output logic              low_start,
    output logic              high_start
);
    localparam int unsigned HALF_W   = RATE_W + 2 * ((1 << PS_W) - 1) + 1;
    localparam int unsigned SYNC_LAT = SYNC_STAGES + 1;

    logic              line_high;
    logic [HALF_W-1:0] half_now;

    scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (scl_sense),
        .line_q  (line_high)
    );

    scl_half_calc #(.RATE_W(RATE_W), .PS_W(PS_W), .HALF_W(HALF_W)) u_calc (
        .rate     (rate),
        .prescale (prescale),
        .half_len (half_now)
    );

    scl_phase_fsm #(.HALF_W(HALF_W), .SYNC_LAT(SYNC_LAT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .hold_low   (hold_low),
        .line_high  (line_high),
        .half_now   (half_now),
        .pull_low   (scl_pull_low),
        .low_start  (low_start),
        .high_start (high_start)
    );
endmodule

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] rate = '0;
    logic [1:0] prescale = '0;
    logic       hold_low = 1'b0;
    logic       other_low = 1'b0;
    logic       scl_sense;
    logic       scl_pull_low, low_start, high_start;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    assign scl_sense = !(scl_pull_low || other_low);

    scl_rate_gen dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rate(rate),
        .prescale(prescale), .scl_sense(scl_sense), .hold_low(hold_low),
        .scl_pull_low(scl_pull_low), .low_start(low_start), .high_start(high_start)
    );

    function automatic int exp_half(input int r, input int p);
        return 8 + r * (4 ** p);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one period: wait for a low start, measure low, stretch, measure release
    task automatic run_period(input int stretch, input bit chg, input int nr, input int np,
                              output int lo, output int hi, output int rises);
        do @(negedge clk); while (!low_start);
        if (chg) begin
            rate = nr[7:0];
            prescale = np[1:0];
        end
        lo = 0;
        while (scl_pull_low) begin
            lo++;
            @(negedge clk);
        end
        other_low = (stretch > 0);
        hi = 0;
        rises = 0;
        while (!scl_pull_low) begin
            hi++;
            if (high_start) rises++;
            if (hi == stretch + 1) other_low = 1'b0;
            @(negedge clk);
        end
        other_low = 1'b0;
    endtask

    task automatic check_setting(input int r, input int p, input string tag);
        int lo, hi, rs, h;
        rate = r[7:0];
        prescale = p[1:0];
        h = exp_half(r, p);
        run_period(0, 1'b0, 0, 0, lo, hi, rs);
        chk(lo == h, {"R3 low half ", tag}, lo, h);
        chk(lo + hi == 2 * h, {"R2 period ", tag}, lo + hi, 2 * h);
        chk(rs == 1, {"R7 one high strobe ", tag}, rs, 1);
    endtask

    task automatic run_all();
        int lo, hi, rs, h, seed_dummy;
        // reset state
        repeat (3) @(negedge clk);
        chk(!scl_pull_low && !low_start && !high_start, "R1 reset outputs",
            {scl_pull_low, low_start, high_start}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!scl_pull_low && !low_start && !high_start, "R1 idle after reset",
            {scl_pull_low, low_start, high_start}, 0);

        // enable: low half begins at next edge with its strobe
        enable = 1'b1;
        @(negedge clk);
        chk(scl_pull_low && low_start, "R6 start on enable",
            {scl_pull_low, low_start}, 3);
        @(negedge clk);
        chk(!low_start, "R7 low strobe one cycle", low_start, 0);

        // directed settings
        check_setting(0, 0, "R=0 x1");
        check_setting(255, 0, "R=255 x1");
        check_setting(5, 1, "R=5 x4");
        check_setting(3, 2, "R=3 x16");
        check_setting(10, 3, "R=10 x64");

        // random settings with a fixed seed
        seed_dummy = $urandom(32'h5C1_0A7E);
        for (int i = 0; i < 10; i++) begin
            int r, p;
            r = int'($urandom_range(127, 0));
            p = int'($urandom_range(2, 0));
            check_setting(r, p, "random");
        end

        // slave stretching
        rate = 8'd2;
        prescale = 2'd1;
        h = exp_half(2, 1);
        run_period(5, 1'b0, 0, 0, lo, hi, rs);
        chk(hi == h + 5, "R4 stretch 5", hi, h + 5);
        chk(rs == 1, "R7 strobe with stretch", rs, 1);
        run_period(40, 1'b0, 0, 0, lo, hi, rs);
        chk(hi == h + 40, "R4 stretch 40", hi, h + 40);
        chk(lo == h, "R3 low unaffected by stretch", lo, h);

        // settings change in mid-period
        run_period(0, 1'b1, 60, 2, lo, hi, rs);
        chk(lo == h, "R8 low keeps old setting", lo, h);
        chk(hi == h, "R8 high keeps old setting", hi, h);
        run_period(0, 1'b0, 0, 0, lo, hi, rs);
        chk(lo == exp_half(60, 2), "R8 new setting next period", lo, exp_half(60, 2));

        // hold request
        rate = 8'd1;
        prescale = 2'd0;
        h = exp_half(1, 0);
        do @(negedge clk); while (!low_start);
        hold_low = 1'b1;
        repeat (3 * h) @(negedge clk);
        chk(scl_pull_low == 1'b1, "R5 held past low half", scl_pull_low, 1);
        hold_low = 1'b0;
        @(negedge clk);
        chk(scl_pull_low == 1'b0, "R5 release after hold drop", scl_pull_low, 0);

        // enable drop
        do @(negedge clk); while (!low_start);
        enable = 1'b0;
        @(negedge clk);
        chk(scl_pull_low == 1'b0, "R6 release on disable", scl_pull_low, 0);
        hold_low = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (scl_pull_low || low_start || high_start)
                chk(1'b0, "R6 quiet while disabled",
                    {scl_pull_low, low_start, high_start}, 0);
        end
        chk(!scl_pull_low, "R6 still released with hold", scl_pull_low, 0);
        hold_low = 1'b0;
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule